// File: doc/BRIEF.md
# PCI Host Bus Bring-Up Sequencer

This block powers up an external PCI bus for a chip that acts as the bus host. It produces a set of register-style control bits: output enables for the bus reset line and the bus clock line, the bus clock enable, a reset-release bit, and the selection of the on-chip arbiter. A single start pulse runs the bring-up in a fixed order, and a `ready` flag tells the rest of the chip when the bus may be used.

The order is fixed. First the two line drivers are enabled while reset is held and the clock is off. Next the clock runs with reset still held for a minimum hold time. Then reset is released, and after that the internal arbiter is chosen. A final settle time must pass before `ready` asserts.

Both minimum times are given in nanoseconds. A system-clock frequency parameter in kHz turns them into cycle counts, rounded up. A start pulse while the bus is ready restarts the whole bring-up. A start pulse during a running sequence has no effect.

Top module: `pci_host_bringup`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) drives every output to 0 on the next cycle: drivers off, clock off, reset held, arbiter not selected, `ready` low.
- R2: One cycle after `start` is sampled high in the idle or ready state, `bus_rst_oe` and `bus_clk_oe` are 1 while `bus_clk_en`, `bus_rst_release`, `arb_internal` and `ready` are 0.
- R3: One cycle after R2, `bus_clk_en` rises with both drivers still enabled and `bus_rst_release` still 0.
- R4: `bus_rst_release` rises exactly HOLD_CYC cycles after `bus_clk_en` rises, where HOLD_CYC = ceil(HOLD_NS * CLK_KHZ / 1e6).
- R5: `arb_internal` rises one cycle after `bus_rst_release`, with clock and drivers kept on.
- R6: `ready` rises exactly SETTLE_CYC cycles after `arb_internal` rises, where SETTLE_CYC = ceil(SETTLE_NS * CLK_KHZ / 1e6).
- R7: A `start` pulse sampled while a sequence is running is ignored: the remaining timing and outputs are unchanged.
- R8: A `start` pulse sampled while `ready` is high restarts the sequence: the next cycle shows the R2 output pattern.
- R9: Without `start`, the idle state keeps all outputs at 0, and the ready state keeps all six outputs at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin (or restart) the bring-up |
| bus_rst_oe | output | 1 | Output enable for the bus reset line driver |
| bus_clk_oe | output | 1 | Output enable for the bus clock line driver |
| bus_clk_en | output | 1 | Bus clock running |
| bus_rst_release | output | 1 | 1 releases the bus reset; 0 holds it asserted |
| arb_internal | output | 1 | Selects the on-chip bus arbiter |
| ready | output | 1 | Bring-up complete; bus may be used |

## Verification
Every output is decoded from the state register, so each result appears one clock after the edge that causes it. The R2 pattern shows one cycle after `start` is sampled, and the clock enable shows one cycle after that. The reset release comes HOLD_CYC cycles after the clock enable, the arbiter select one cycle after the release, and `ready` SETTLE_CYC cycles after the arbiter select. The bench drives inputs and samples outputs on the falling edge. It counts falling edges from the one where `start` is dropped. It checks each bit on the last cycle before its change and again on the first cycle after it. The bench shortens the sequence to a 1.5 MHz frequency, so the settle time of 1.5 cycles rounds up to 2.

// File: rtl/pcihb_pkg.sv
package pcihb_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE  = 3'd0,
      SQ_DRV   = 3'd1,
      SQ_CLKON = 3'd2,
      SQ_REL   = 3'd3,
      SQ_ARB   = 3'd4,
      SQ_RDY   = 3'd5
   } seq_state_e;

   typedef struct packed {
      logic rst_oe;
      logic clk_oe;
      logic clk_en;
      logic rst_rel;
      logic arb_int;
      logic rdy;
   } bus_ctrl_t;

   // ceil(ns * khz / 1e6) in 64-bit arithmetic
   function automatic int unsigned ns_to_cycles(input longint unsigned ns,
                                                input longint unsigned khz);
      longint unsigned prod;
      prod = ns * khz;
      return int'((prod + 64'd999999) / 64'd1000000);
   endfunction

endpackage

// File: rtl/pcihb_timer.sv
module pcihb_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          done
);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)                cnt <= '0;
      else if (load)          cnt <= load_val;
      else if (cnt != '0)     cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);

   // R4 R6: the interval counter steps down by one each idle cycle
   count_step_chk: assert property (@(posedge clk) disable iff (rst)
      (!load && cnt != '0) |=> (cnt == CW'($past(cnt) - 1'b1)));

endmodule

// File: rtl/pcihb_fsm.sv
module pcihb_fsm
   import pcihb_pkg::*;
#(
   parameter int CW         = 8,
   parameter int HOLD_CYC   = 4,
   parameter int SETTLE_CYC = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic          tmr_done,
   output logic          tmr_load,
   output logic [CW-1:0] tmr_val,
   output seq_state_e    state
);

   localparam logic [CW-1:0] HOLD_LD   = CW'(HOLD_CYC - 1);
   localparam logic [CW-1:0] SETTLE_LD = CW'(SETTLE_CYC - 1);

   seq_state_e nxt;

   always_comb begin
      nxt      = state;
      tmr_load = 1'b0;
      tmr_val  = HOLD_LD;
      unique case (state)
         SQ_IDLE:  if (start) nxt = SQ_DRV;
         SQ_DRV: begin
            nxt      = SQ_CLKON;
            tmr_load = 1'b1;
            tmr_val  = HOLD_LD;
         end
         SQ_CLKON: if (tmr_done) nxt = SQ_REL;
         SQ_REL: begin
            nxt      = SQ_ARB;
            tmr_load = 1'b1;
            tmr_val  = SETTLE_LD;
         end
         SQ_ARB:   if (tmr_done) nxt = SQ_RDY;
         SQ_RDY:   if (start) nxt = SQ_DRV;
         default:  nxt = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state <= SQ_IDLE;
      else     state <= nxt;
   end

   logic busy;
   assign busy = (state == SQ_DRV) || (state == SQ_CLKON) ||
                 (state == SQ_REL) || (state == SQ_ARB);

   // R7
   start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && start) |=> (state != SQ_DRV));

endmodule

// File: rtl/pcihb_decode.sv
module pcihb_decode
   import pcihb_pkg::*;
(
   input  seq_state_e state,
   output bus_ctrl_t  ctrl
);

   always_comb begin
      ctrl = '0;
      unique case (state)
         SQ_IDLE:  ctrl = '0;
         SQ_DRV:   ctrl = '{rst_oe:1'b1, clk_oe:1'b1, default:1'b0};
         SQ_CLKON: ctrl = '{rst_oe:1'b1, clk_oe:1'b1, clk_en:1'b1, default:1'b0};
         SQ_REL:   ctrl = '{rdy:1'b0, arb_int:1'b0, default:1'b1};
         SQ_ARB:   ctrl = '{rdy:1'b0, default:1'b1};
         SQ_RDY:   ctrl = '1;
         default:  ctrl = '0;
      endcase
   end

endmodule

// File: rtl/pci_host_bringup.sv
module pci_host_bringup
   import pcihb_pkg::*;
#(
   parameter int CLK_KHZ   = 50000,
   parameter int HOLD_NS   = 150000,
   parameter int SETTLE_NS = 1000
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic bus_rst_oe,
   output logic bus_clk_oe,
   output logic bus_clk_en,
   output logic bus_rst_release,
   output logic arb_internal,
   output logic ready
);

   localparam int HOLD_CYC   = int'(ns_to_cycles(longint'(HOLD_NS), longint'(CLK_KHZ)));
   localparam int SETTLE_CYC = int'(ns_to_cycles(longint'(SETTLE_NS), longint'(CLK_KHZ)));
   localparam int MAX_CYC    = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
   localparam int CW         = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC + 1);
   localparam int MW         = $clog2(MAX_CYC + 2);

   if (CLK_KHZ < 1) begin : g_bad_clk
      $error("CLK_KHZ must be at least 1");
   end
   if (HOLD_CYC < 1 || SETTLE_CYC < 1) begin : g_bad_delay
      $error("hold and settle times must each give at least one cycle");
   end

   logic          tmr_load;
   logic          tmr_done;
   logic [CW-1:0] tmr_val;
   seq_state_e    state;
   bus_ctrl_t     ctrl;

   pcihb_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   pcihb_fsm #(
      .CW         (CW),
      .HOLD_CYC   (HOLD_CYC),
      .SETTLE_CYC (SETTLE_CYC)
   ) u_fsm (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .tmr_done (tmr_done),
      .tmr_load (tmr_load),
      .tmr_val  (tmr_val),
      .state    (state)
   );

   pcihb_decode u_decode (
      .state (state),
      .ctrl  (ctrl)
   );

   assign bus_rst_oe      = ctrl.rst_oe;
   assign bus_clk_oe      = ctrl.clk_oe;
   assign bus_clk_en      = ctrl.clk_en;
   assign bus_rst_release = ctrl.rst_rel;
   assign arb_internal    = ctrl.arb_int;
   assign ready           = ctrl.rdy;

   // interval observers for the timing properties
   logic [MW-1:0] hold_seen;
   logic [MW-1:0] settle_seen;

   always_ff @(posedge clk) begin
      if (rst || !bus_clk_en)
         hold_seen <= '0;
      else if (!bus_rst_release && hold_seen != '1)
         hold_seen <= hold_seen + 1'b1;
      if (rst || !arb_internal)
         settle_seen <= '0;
      else if (!ready && settle_seen != '1)
         settle_seen <= settle_seen + 1'b1;
   end

   // R1
   reset_clears_chk: assert property (@(posedge clk)
      rst |=> !(bus_rst_oe || bus_clk_oe || bus_clk_en ||
                bus_rst_release || arb_internal || ready));

   // R3
   clk_after_drivers_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(bus_clk_en) |-> (bus_rst_oe && bus_clk_oe && !bus_rst_release &&
                             $past(bus_rst_oe) && $past(bus_clk_oe)));

   // R4
   hold_time_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(bus_rst_release) |-> (hold_seen == MW'(HOLD_CYC)));

   // R5
   arb_after_release_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(arb_internal) |-> ($past(bus_rst_release) && bus_clk_en));

   // R6
   settle_time_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(ready) |-> (settle_seen == MW'(SETTLE_CYC)));

   // R9
   ready_holds_chk: assert property (@(posedge clk) disable iff (rst)
      (ready && !start) |=> ready);

endmodule

// File: tb/pci_host_bringup_tb.sv
module pci_host_bringup_tb;

   localparam int TB_KHZ    = 1500;
   localparam int TB_HOLD   = 150000;
   localparam int TB_SETTLE = 1000;
   // expected counts, rounded up: 225 and 2 (1.5 rounds to 2)
   localparam int EXP_HOLD   = (TB_HOLD * TB_KHZ + 999999) / 1000000;
   localparam int EXP_SETTLE = (TB_SETTLE * TB_KHZ + 999999) / 1000000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0;
   logic rst_oe, clk_oe, clk_en, rel, arb, rdy;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   pci_host_bringup #(
      .CLK_KHZ   (TB_KHZ),
      .HOLD_NS   (TB_HOLD),
      .SETTLE_NS (TB_SETTLE)
   ) u_dut (
      .clk             (clk),
      .rst             (rst),
      .start           (start),
      .bus_rst_oe      (rst_oe),
      .bus_clk_oe      (clk_oe),
      .bus_clk_en      (clk_en),
      .bus_rst_release (rel),
      .arb_internal    (arb),
      .ready           (rdy)
   );

   // bit order: rst_oe clk_oe clk_en release arb ready
   function automatic logic [5:0] outs();
      return {rst_oe, clk_oe, clk_en, rel, arb, rdy};
   endfunction

   task automatic chk(input string req, input logic [5:0] exp);
      checks++;
      if (outs() !== exp) begin
         fails++;
         $display("FAIL %s: got %b expected %b at %0t", req, outs(), exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1; start = 1'b0;
      @(negedge clk);
      chk("R1 reset", 6'b000000);
      rst = 1'b0;
   endtask

   // start pulse, then step through the sequence; inj > 0 pulses start
   // again inside the clock-on hold window (R7)
   task automatic run_seq(input string tag, input int inj);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk({tag, " R2 drivers"}, 6'b110000);
      @(negedge clk);
      chk({tag, " R3 clock on"}, 6'b111000);
      for (int i = 1; i < EXP_HOLD; i++) begin
         @(negedge clk);
         start = (i == inj);
         if (i == EXP_HOLD - 1) chk({tag, " R4 R7 still held"}, 6'b111000);
      end
      @(negedge clk); start = 1'b0;
      chk({tag, " R4 release"}, 6'b111100);
      @(negedge clk);
      chk({tag, " R5 arbiter"}, 6'b111110);
      for (int i = 1; i < EXP_SETTLE; i++) @(negedge clk);
      chk({tag, " R6 not yet ready"}, 6'b111110);
      @(negedge clk);
      chk({tag, " R6 ready"}, 6'b111111);
   endtask

   task automatic t_idle_quiet();
      do_reset();
      repeat (5) @(negedge clk);
      chk("R9 idle stays off", 6'b000000);
   endtask

   task automatic t_ready_hold();
      repeat (8) @(negedge clk);
      chk("R9 ready holds", 6'b111111);
   endtask

   task automatic t_restart();
      run_seq("R8 restart", 0);
   endtask

   task automatic t_reset_mid();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (20) @(negedge clk);
      chk("R1 pre-reset clock on", 6'b111000);
      do_reset();
      repeat (3) @(negedge clk);
      chk("R1 stays idle", 6'b000000);
   endtask

   initial begin
      do_reset();
      t_idle_quiet();
      run_seq("basic", 0);
      t_ready_hold();
      t_restart();
      t_reset_mid();
      run_seq("R7 mid start", 40);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule